// File: doc/BRIEF.md
# CAN Transmit Command Sequencer

This block sits between the command register of a CAN controller and its bit-level transmitter. A write to the 8-bit command register can do several things. It can queue one or more of three transmit buffers, cancel requests that have not started yet, pick a single-shot mode or a self-reception mode, and send housekeeping pulses to the receive path. Each command bit acts only in the cycle of the write. The register always reads back as zero.

The block keeps a pending flag for each buffer. Whenever the transmitter is idle, it grants the lowest-numbered pending buffer. The granted buffer stays owned by the transmitter until one of three results comes back: complete, bus error or arbitration lost. On completion the pending flag clears and a done pulse is raised for that buffer. In normal mode an error or a lost arbitration leaves the buffer pending, so it is sent again. In single-shot mode the buffer is dropped after its first attempt, whatever the result. In self-reception mode the receiver stays enabled while the frame goes out, so the node can accept its own frame.

Top module: `can_txcmd_seq`

## Requirements
- R1: After reset every output is low, and `tx_idx` is 0.
- R2: `cmd_rdata` is always 0.
- R3: A write with bit 0 (send request) set marks pending each buffer whose select bit is set. Bit 5 selects buffer 0, bit 6 buffer 1 and bit 7 buffer 2. When the transmitter is idle, `tx_go` pulses for one cycle, two clock edges after the write edge, with `tx_idx` naming the buffer.
- R4: When several buffers are pending, the lowest-numbered one is granted first.
- R5: `tx_busy` rises with `tx_go` and stays high, with `tx_idx` held, until `tx_done`, `tx_err` or `tx_arb_lost` is sampled. While it is high, no new grant is made, and writes that select the owned buffer leave it unchanged.
- R6: `tx_done` clears the owned buffer's pending flag, and `buf_done` pulses for that buffer in the next cycle.
- R7: With bit 1 (abort) clear and bit 4 clear, a send request uses normal mode. After an error or a lost arbitration, the buffer stays pending and is granted again.
- R8: Bits 0 and 1 written together give single-shot mode. `tx_oneshot` is high while that buffer is owned. An error or a lost arbitration then drops the buffer, and no done pulse follows.
- R9: Bit 1 written without bit 0 and without bit 4 cancels the selected pending buffers that are not owned. It has no effect on a buffer that is owned or that is being granted in the same cycle.
- R10: Bit 4 (self-reception) queues the selected buffers, and `tx_selfrx` is high while such a buffer is owned.
  - Bit 4 alone retries after an error.
  - Bits 4 and 0 together also give single-shot mode.
  - Bits 0, 1 and 4 together give single-shot mode without self-reception.
- R11: Bit 2 makes `rx_release` pulse, and bit 3 makes `ovr_clear` pulse. Each pulse lasts one cycle and comes in the cycle after the write.
- R12: A write that sets only select bits has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command write data |
| cmd_rdata | output | 8 | Command register read value (always 0) |
| tx_go | output | 1 | One-cycle grant pulse to the transmitter |
| tx_idx | output | 2 | Index of the owned buffer |
| tx_busy | output | 1 | A buffer is owned by the transmitter |
| tx_oneshot | output | 1 | The owned buffer is in single-shot mode |
| tx_selfrx | output | 1 | Keep the receiver enabled for the owned frame |
| tx_done | input | 1 | Transmitter reports success |
| tx_err | input | 1 | Transmitter reports a bus error |
| tx_arb_lost | input | 1 | Transmitter reports lost arbitration |
| buf_done | output | 3 | Per-buffer completion pulse |
| rx_release | output | 1 | Receive buffer release pulse |
| ovr_clear | output | 1 | Data overrun clear pulse |

## Verification
A wrong pending flag or mode bit shows up at the ports as a missing grant, an extra grant, or a wrong `tx_oneshot` or `tx_selfrx` level. This appears at the next idle point, one edge after a result is reported. A corrupted owner register changes `tx_idx` or `buf_done` in the cycle right after the fault. A decode error appears two edges after the write, as a wrong grant, or one edge after it, as a wrong pulse. The bench compares the ports against its own model on every clock, so each of these faults is caught within a few cycles.

// File: rtl/can_txcmd_pkg.sv
package can_txcmd_pkg;
  // Command bit positions (the select field starts at SEL_LSB, one bit per buffer)
  localparam int BIT_SEND  = 0;
  localparam int BIT_ABORT = 1;
  localparam int BIT_REL   = 2;
  localparam int BIT_OVR   = 3;
  localparam int BIT_SELF  = 4;
  localparam int SEL_LSB   = 5;

  typedef struct packed {
    logic send;
    logic abort;
    logic rel;
    logic ovr;
    logic self;
  } cmd_flags_t;

  // Single-shot when a send request is combined with abort or self-reception
  function automatic logic mode_oneshot(input cmd_flags_t f);
    return f.send & (f.abort | f.self);
  endfunction

  // Self-reception unless send+abort forces plain single-shot
  function automatic logic mode_selfrx(input cmd_flags_t f);
    return f.self & ~(f.send & f.abort);
  endfunction

  function automatic logic is_queue(input cmd_flags_t f);
    return f.send | f.self;
  endfunction

  function automatic logic is_cancel(input cmd_flags_t f);
    return f.abort & ~f.send & ~f.self;
  endfunction
endpackage

// File: rtl/can_txcmd_decode.sv
module can_txcmd_decode
  import can_txcmd_pkg::*;
#(
  parameter int NBUF  = 3,
  parameter int CMD_W = SEL_LSB + NBUF
) (
  input  logic             we,
  input  logic [CMD_W-1:0] wdata,
  output cmd_flags_t       flags,
  output logic [NBUF-1:0]  sel
);
  always_comb begin
    flags       = '0;
    sel         = '0;
    if (we) begin
      flags.send  = wdata[BIT_SEND];
      flags.abort = wdata[BIT_ABORT];
      flags.rel   = wdata[BIT_REL];
      flags.ovr   = wdata[BIT_OVR];
      flags.self  = wdata[BIT_SELF];
      sel         = wdata[SEL_LSB +: NBUF];
    end
  end
endmodule

// File: rtl/can_txcmd_arb.sv
module can_txcmd_arb #(
  parameter int NBUF  = 3,
  parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [NBUF-1:0]  req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/can_txcmd_bufs.sv
module can_txcmd_bufs #(
  parameter int NBUF = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] set_mask,
  input  logic [NBUF-1:0] clr_mask,
  input  logic            set_oneshot,
  input  logic            set_selfrx,
  output logic [NBUF-1:0] pend,
  output logic [NBUF-1:0] oneshot,
  output logic [NBUF-1:0] selfrx
);
  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g]    <= 1'b0;
        oneshot[g] <= 1'b0;
        selfrx[g]  <= 1'b0;
      end else if (set_mask[g]) begin
        pend[g]    <= 1'b1;
        oneshot[g] <= set_oneshot;
        selfrx[g]  <= set_selfrx;
      end else if (clr_mask[g]) begin
        pend[g]    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_txcmd_seq.sv
module can_txcmd_seq
  import can_txcmd_pkg::*;
#(
  parameter int NBUF  = 3,
  parameter int CMD_W = SEL_LSB + NBUF,
  parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic [CMD_W-1:0] cmd_rdata,
  output logic             tx_go,
  output logic [IDX_W-1:0] tx_idx,
  output logic             tx_busy,
  output logic             tx_oneshot,
  output logic             tx_selfrx,
  input  logic             tx_done,
  input  logic             tx_err,
  input  logic             tx_arb_lost,
  output logic [NBUF-1:0]  buf_done,
  output logic             rx_release,
  output logic             ovr_clear
);
  cmd_flags_t       flags;
  logic [NBUF-1:0]  sel;
  logic [NBUF-1:0]  pend, os_vec, sr_vec;
  logic             grant_any;
  logic [IDX_W-1:0] grant_idx;

  // Named internal events
  logic             grant_fire;
  logic             result_fire;
  logic             result_drop;
  logic [NBUF-1:0]  owned_mask;
  logic [NBUF-1:0]  protect_mask;
  logic [NBUF-1:0]  wr_set, wr_clr, res_clr;

  logic             busy_q;
  logic [IDX_W-1:0] owner_q;
  logic             go_q, rel_q, ovr_q;
  logic [NBUF-1:0]  done_q;

  can_txcmd_decode #(.NBUF(NBUF), .CMD_W(CMD_W)) dec_i (
    .we(cmd_we), .wdata(cmd_wdata), .flags(flags), .sel(sel)
  );

  can_txcmd_arb #(.NBUF(NBUF), .IDX_W(IDX_W)) arb_i (
    .req(pend), .any(grant_any), .idx(grant_idx)
  );

  function automatic logic [NBUF-1:0] onehot_of(input logic [IDX_W-1:0] i);
    return NBUF'(1) << i;
  endfunction

  always_comb begin
    grant_fire   = !busy_q && grant_any;
    result_fire  = busy_q && (tx_done || tx_err || tx_arb_lost);
    result_drop  = result_fire && (tx_done || os_vec[owner_q]);
    owned_mask   = busy_q ? onehot_of(owner_q) : '0;
    protect_mask = owned_mask | (grant_fire ? onehot_of(grant_idx) : '0);
    wr_set       = is_queue(flags)  ? (sel & ~protect_mask) : '0;
    wr_clr       = is_cancel(flags) ? (sel & ~protect_mask) : '0;
    res_clr      = result_drop ? onehot_of(owner_q) : '0;
  end

  can_txcmd_bufs #(.NBUF(NBUF)) bufs_i (
    .clk(clk), .rst_n(rst_n),
    .set_mask(wr_set), .clr_mask(wr_clr | res_clr),
    .set_oneshot(mode_oneshot(flags)), .set_selfrx(mode_selfrx(flags)),
    .pend(pend), .oneshot(os_vec), .selfrx(sr_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      go_q    <= 1'b0;
      done_q  <= '0;
      rel_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      go_q   <= grant_fire;
      done_q <= (result_fire && tx_done) ? onehot_of(owner_q) : '0;
      rel_q  <= flags.rel;
      ovr_q  <= flags.ovr;
      if (grant_fire) begin
        busy_q  <= 1'b1;
        owner_q <= grant_idx;
      end else if (result_fire) begin
        busy_q  <= 1'b0;
      end
    end
  end

  assign cmd_rdata  = '0;
  assign tx_go      = go_q;
  assign tx_idx     = owner_q;
  assign tx_busy    = busy_q;
  assign tx_oneshot = busy_q & os_vec[owner_q];
  assign tx_selfrx  = busy_q & sr_vec[owner_q];
  assign buf_done   = done_q;
  assign rx_release = rel_q;
  assign ovr_clear  = ovr_q;
endmodule

// File: rtl/can_txcmd_chk.sv
module can_txcmd_chk #(
  parameter int NBUF  = 3,
  parameter int CMD_W = 8,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [CMD_W-1:0] cmd_wdata,
  input logic [CMD_W-1:0] cmd_rdata,
  input logic             tx_go,
  input logic [IDX_W-1:0] tx_idx,
  input logic             tx_busy,
  input logic             tx_oneshot,
  input logic             tx_selfrx,
  input logic             tx_done,
  input logic             tx_err,
  input logic             tx_arb_lost,
  input logic [NBUF-1:0]  buf_done,
  input logic             rx_release,
  input logic             ovr_clear
);
  AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cmd_rdata == '0); // R2
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tx_go |=> !tx_go); // R3
  AST_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n) tx_go |-> tx_busy); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_done && !tx_err && !tx_arb_lost) |=> (tx_busy && $stable(tx_idx))); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|buf_done) |-> $past(tx_done && tx_busy)); // R6
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(buf_done)); // R6
  AST_ONESHOT_OWNED: assert property (@(posedge clk) disable iff (!rst_n) tx_oneshot |-> tx_busy); // R8
  AST_SELFRX_OWNED: assert property (@(posedge clk) disable iff (!rst_n) tx_selfrx |-> tx_busy); // R10
  AST_REL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_release |-> $past(cmd_we && cmd_wdata[2])); // R11
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clear |-> $past(cmd_we && cmd_wdata[3])); // R11
endmodule

bind can_txcmd_seq can_txcmd_chk #(.NBUF(NBUF), .CMD_W(CMD_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .cmd_rdata(cmd_rdata), .tx_go(tx_go), .tx_idx(tx_idx), .tx_busy(tx_busy),
  .tx_oneshot(tx_oneshot), .tx_selfrx(tx_selfrx), .tx_done(tx_done),
  .tx_err(tx_err), .tx_arb_lost(tx_arb_lost), .buf_done(buf_done),
  .rx_release(rx_release), .ovr_clear(ovr_clear)
);

// File: tb/can_txcmd_seq_tb.sv
module can_txcmd_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] cmd_rdata;
  logic       tx_go, tx_busy, tx_oneshot, tx_selfrx;
  logic [1:0] tx_idx;
  logic       tx_done = 1'b0, tx_err = 1'b0, tx_arb_lost = 1'b0;
  logic [2:0] buf_done;
  logic       rx_release, ovr_clear;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  can_txcmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .tx_go(tx_go), .tx_idx(tx_idx), .tx_busy(tx_busy),
    .tx_oneshot(tx_oneshot), .tx_selfrx(tx_selfrx), .tx_done(tx_done),
    .tx_err(tx_err), .tx_arb_lost(tx_arb_lost), .buf_done(buf_done),
    .rx_release(rx_release), .ovr_clear(ovr_clear)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_pend[3], m_os[3], m_sr[3];
  bit m_busy, m_go, m_rel, m_ovr;
  int m_own;
  bit [2:0] m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_os[i] = 0; m_sr[i] = 0; end
      m_busy = 0; m_own = 0; m_go = 0; m_done = '0; m_rel = 0; m_ovr = 0;
    end else begin
      bit grant; int gi; bit snd, abt, slf;
      bit busy_before; int own_before;
      grant = 0; gi = 0;
      busy_before = m_busy; own_before = m_own;
      if (!m_busy) begin
        for (int i = 2; i >= 0; i--) if (m_pend[i]) begin grant = 1; gi = i; end
      end
      m_done = '0;
      if (m_busy && (tx_done || tx_err || tx_arb_lost)) begin
        if (tx_done) begin m_pend[m_own] = 0; m_done[m_own] = 1; end
        else if (m_os[m_own]) m_pend[m_own] = 0;
        m_busy = 0;
      end
      snd = cmd_we && cmd_wdata[0];
      abt = cmd_we && cmd_wdata[1];
      slf = cmd_we && cmd_wdata[4];
      for (int i = 0; i < 3; i++) begin
        bit prot;
        prot = (busy_before && own_before == i) || (grant && gi == i);
        if (cmd_we && cmd_wdata[5+i] && !prot) begin
          if (snd || slf) begin
            m_pend[i] = 1;
            m_os[i] = snd && (abt || slf);
            m_sr[i] = slf && !(snd && abt);
          end else if (abt) m_pend[i] = 0;
        end
      end
      m_rel = cmd_we && cmd_wdata[2];
      m_ovr = cmd_we && cmd_wdata[3];
      m_go = grant;
      if (grant) begin m_busy = 1; m_own = gi; end
    end
  end

  // Cycle compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cmd_rdata == 8'h00, "R2", "cmd_rdata", cmd_rdata, 0);
      check(tx_go == m_go, "R3", "tx_go", tx_go, m_go);
      check(tx_busy == m_busy, "R5", "tx_busy", tx_busy, m_busy);
      if (m_busy) check(tx_idx == m_own, "R5", "tx_idx", tx_idx, m_own);
      check(buf_done == m_done, "R6", "buf_done", buf_done, m_done);
      check(tx_oneshot == (m_busy && m_os[m_own]), "R8", "tx_oneshot",
            tx_oneshot, m_busy && m_os[m_own]);
      check(tx_selfrx == (m_busy && m_sr[m_own]), "R10", "tx_selfrx",
            tx_selfrx, m_busy && m_sr[m_own]);
      check(rx_release == m_rel, "R11", "rx_release", rx_release, m_rel);
      check(ovr_clear == m_ovr, "R11", "ovr_clear", ovr_clear, m_ovr);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = d;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  // Waits for a grant (at a negedge) and checks its index and modes
  task automatic wait_go(input int idx, input bit os, input bit sr, input string tag);
    int n = 0;
    while (!tx_go && n < 20) begin @(negedge clk); n++; end
    check(tx_go == 1'b1, tag, "grant seen", tx_go, 1);
    check(tx_idx == idx, tag, "grant index", tx_idx, idx);
    check(tx_oneshot == os, tag, "grant oneshot", tx_oneshot, os);
    check(tx_selfrx == sr, tag, "grant selfrx", tx_selfrx, sr);
  endtask

  // Result: 0 done, 1 error, 2 arbitration lost; driven right after the grant
  task automatic respond(input int kind);
    tx_done = (kind == 0); tx_err = (kind == 1); tx_arb_lost = (kind == 2);
    @(negedge clk); tx_done = 0; tx_err = 0; tx_arb_lost = 0;
  endtask

  task automatic expect_idle(input int n, input string tag);
    int gos = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); gos += int'(tx_go) + int'(tx_busy); end
    check(gos == 0, tag, "no grant while idle", gos, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({tx_go, tx_busy, tx_oneshot, tx_selfrx, buf_done, rx_release, ovr_clear} == '0
          && tx_idx == 0 && cmd_rdata == 0, "R1", "reset outputs", 1, 0);

    // R3: single request on buffer 1
    wr(8'h41); wait_go(1, 0, 0, "R3"); respond(0);
    expect_idle(4, "R6");

    // R4: three buffers, lowest first
    wr(8'hE1);
    wait_go(0, 0, 0, "R4"); respond(0);
    wait_go(1, 0, 0, "R4"); respond(0);
    wait_go(2, 0, 0, "R4"); respond(0);
    expect_idle(4, "R4");

    // R7: normal mode retries after error and lost arbitration
    wr(8'h81);
    wait_go(2, 0, 0, "R7"); respond(1);
    wait_go(2, 0, 0, "R7"); respond(2);
    wait_go(2, 0, 0, "R7"); respond(0);
    expect_idle(4, "R7");

    // R8: single shot dropped after lost arbitration, no done pulse
    wr(8'h23); wait_go(0, 1, 0, "R8"); respond(2);
    expect_idle(5, "R8");

    // R9: cancel not-started buffer 1 while buffer 0 is owned
    wr(8'h61); wait_go(0, 0, 0, "R9");
    wr(8'h62);
    check(tx_busy == 1 && tx_idx == 0, "R9", "owned buffer survives abort", tx_busy, 1);
    respond(0);
    expect_idle(5, "R9");

    // R5: writes to the owned buffer are ignored
    wr(8'h21); wait_go(0, 0, 0, "R5");
    wr(8'h23);
    check(tx_oneshot == 0, "R5", "owned mode unchanged", tx_oneshot, 0);
    respond(0);
    expect_idle(5, "R5");

    // R10: self-reception variants
    wr(8'h50); wait_go(1, 0, 1, "R10"); respond(1);
    wait_go(1, 0, 1, "R10"); respond(0);
    wr(8'h31); wait_go(0, 1, 1, "R10"); respond(1);
    expect_idle(4, "R10");
    wr(8'h33); wait_go(0, 1, 0, "R10"); respond(0);
    expect_idle(4, "R10");

    // R11: receive-side pulses
    wr(8'h04); wr(8'h08); wr(8'h0C);

    // R12: select bits alone do nothing
    wr(8'hE0);
    expect_idle(6, "R12");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule